// File: doc/BRIEF.md
# Coarse-Fine Interval Time Digitizer

This block measures the time between a rising edge on a start input and a later rising edge on a stop input, and reports the interval as one binary word. A synchronous counter running on the reference clock supplies the coarse part, counted in whole clock periods. An external interpolator provides a sub-period code with a valid strobe, and that code fills the low bits of the word.

The raw start and stop lines are asynchronous to the clock and go through two flip-flops before any logic uses them. When stop arrives during a measurement, the coarse count and the fine code are written together into a result register, and a one-cycle valid pulse is issued. If the interval reaches full scale, the coarse field saturates at all ones and an overflow flag is raised alongside the result. Full scale is one clock period times 2^CW.

Top module: `interval_digitizer`

## Requirements
- R1: The coarse field equals D, the number of clock cycles between the clock edges at which the start and stop rising edges are first sampled. Both lines pass through identical two-flop synchronizers.
- R2: The result word carries the coarse count in its upper CW bits and the fine field in its lower FW bits.
- R3: The fine field takes the value of fine_code_i when fine_vld_i is high in the cycle the stop edge is processed. Otherwise the fine field is zero.
- R4: When D is 2^CW or more, the coarse field reads all ones and ovf_o is 1. When D is 2^CW-1 or less, ovf_o is 0 and the count is exact.
- R5: result_vld_o is high for exactly one cycle per completed measurement. It appears within four clock cycles of the stop input rising.
- R6: A stop edge with no measurement in progress is ignored. No valid pulse follows, and result_o and ovf_o keep their values.
- R7: A start edge during a measurement restarts it, and the interval is counted from the latest start.
- R8: When start and stop edges are processed in the same cycle, start wins. The run restarts and no result is produced.
- R9: Reset (rst_n low) clears the counter, the result word, result_vld_o and ovf_o.
- R10: result_o and ovf_o hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its period is the coarse unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Raw start line, rising edge begins a measurement |
| stop_i | input | 1 | Raw stop line, rising edge ends a measurement |
| fine_code_i | input | FW | Sub-period code from the external interpolator |
| fine_vld_i | input | 1 | Qualifies fine_code_i |
| result_o | output | CW+FW | {coarse count, fine field} |
| result_vld_o | output | 1 | One-cycle pulse when result_o is updated |
| ovf_o | output | 1 | Interval reached full scale for the current result |

## Verification
The bench sweeps every interval from one cycle to beyond full scale on a small configuration. This places the exact all-ones count and the first overflowing interval next to each other. A counter that wraps instead of saturating, or that flags overflow one cycle early or late, gives a wrong value at one of these two points. An off-by-one in how the count is loaded shows up at every interval, and most plainly at D=1. Further cases cover a stop with no start, a restart in mid-run, and coincident start and stop. A design that handles any of these wrongly emits a spurious valid pulse, changes the held result, or measures from the wrong start.

// File: rtl/interval_digitizer.sv
module interval_digitizer #(
  parameter int CW = 8,
  parameter int FW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [FW-1:0]      fine_code_i,
  input  logic               fine_vld_i,
  output logic [CW+FW-1:0]   result_o,
  output logic               result_vld_o,
  output logic               ovf_o
);
  localparam int RW = CW + FW;

  logic [2:0]    st_sh, sp_sh;
  logic          run_q, sat_q;
  logic [CW-1:0] cnt_q;
  logic          start_hit, stop_hit;
  logic [FW-1:0] fine_sel;

  assign start_hit = st_sh[1] & ~st_sh[2];
  assign stop_hit  = sp_sh[1] & ~sp_sh[2];
  assign fine_sel  = fine_vld_i ? fine_code_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sh <= '0;
      sp_sh <= '0;
    end else begin
      st_sh <= {st_sh[1:0], start_i};
      sp_sh <= {sp_sh[1:0], stop_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      sat_q        <= 1'b0;
      cnt_q        <= '0;
      result_o     <= '0;
      result_vld_o <= 1'b0;
      ovf_o        <= 1'b0;
    end else begin
      result_vld_o <= 1'b0;
      if (start_hit) begin
        run_q <= 1'b1;
        sat_q <= 1'b0;
        cnt_q <= CW'(1);
      end else if (run_q && stop_hit) begin
        run_q        <= 1'b0;
        result_o     <= RW'({cnt_q, fine_sel});
        result_vld_o <= 1'b1;
        ovf_o        <= sat_q;
      end else if (run_q) begin
        if (&cnt_q) sat_q <= 1'b1;
        else        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/interval_digitizer_chk.sv
module interval_digitizer_chk #(
  parameter int CW = 8,
  parameter int FW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW+FW-1:0] result_o,
  input logic             result_vld_o,
  input logic             ovf_o
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);

  a_r4_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (&result_o[CW+FW-1:FW]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld_o |-> ($stable(result_o) && $stable(ovf_o)));

  a_r1_coarse_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |-> (result_o[CW+FW-1:FW] != '0));

  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (result_o == '0 && !result_vld_o && !ovf_o));
endmodule

bind interval_digitizer interval_digitizer_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .result_o(result_o),
  .result_vld_o(result_vld_o), .ovf_o(ovf_o));

// File: tb/sim_interval_digitizer.sv
module sim_interval_digitizer;
  localparam int CW = 4;
  localparam int FW = 2;
  localparam int RW = CW + FW;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_r = 1'b0, stop_r = 1'b0;
  logic [FW-1:0] fcode = '0;
  logic fvld = 1'b0;
  logic [RW-1:0] res;
  logic res_vld, ovf;
  int total = 0, bad = 0;

  interval_digitizer #(.CW(CW), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_r), .stop_i(stop_r),
    .fine_code_i(fcode), .fine_vld_i(fvld),
    .result_o(res), .result_vld_o(res_vld), .ovf_o(ovf));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic collect(int n, output int hits, output logic [RW-1:0] r, output logic o);
    hits = 0; r = res; o = ovf;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (res_vld) begin hits++; r = res; o = ovf; end
    end
  endtask

  task automatic pulse_start_then_stop(int d);
    @(negedge clk); start_r = 1'b1;
    for (int i = 0; i < d; i++) begin @(negedge clk); start_r = 1'b0; end
    stop_r = 1'b1;
    @(negedge clk); stop_r = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h; logic [RW-1:0] r; logic o; logic [RW-1:0] held; logic hovf;
    repeat (3) @(negedge clk);
    chk("R9 result", int'(res), 0);
    chk("R9 vld", int'(res_vld), 0);
    chk("R9 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5: sweep across full scale
    for (int d = 1; d <= 19; d++) begin
      int ec, ef;
      fcode = FW'(d % 4);
      fvld  = (d % 3) != 0;
      pulse_start_then_stop(d);
      collect(8, h, r, o);
      ec = (d >= (1 << CW)) ? (1 << CW) - 1 : d;
      ef = fvld ? d % 4 : 0;
      chk("R5 one pulse", h, 1);
      chk("R1 coarse", int'(r[RW-1:FW]), ec);
      chk("R3 fine", int'(r[FW-1:0]), ef);
      chk("R2 word", int'(r), (ec << FW) | ef);
      chk("R4 ovf", int'(o), (d >= (1 << CW)) ? 1 : 0);
    end

    // R6 R10: stop with no start
    held = res; hovf = ovf;
    @(negedge clk); stop_r = 1'b1;
    @(negedge clk); stop_r = 1'b0;
    collect(8, h, r, o);
    chk("R6 no pulse", h, 0);
    chk("R10 result held", int'(res), int'(held));
    chk("R10 ovf held", int'(ovf), int'(hovf));

    // R7: restart mid-run
    fcode = 2'd1; fvld = 1'b1;
    @(negedge clk); start_r = 1'b1;
    @(negedge clk); start_r = 1'b0;
    repeat (4) @(negedge clk);
    pulse_start_then_stop(7);
    collect(8, h, r, o);
    chk("R7 pulses", h, 1);
    chk("R7 coarse", int'(r[RW-1:FW]), 7);

    // R8: start and stop together while running
    @(negedge clk); start_r = 1'b1;
    @(negedge clk); start_r = 1'b0;
    repeat (3) @(negedge clk);
    start_r = 1'b1; stop_r = 1'b1;
    @(negedge clk); start_r = 1'b0; stop_r = 1'b0;
    collect(8, h, r, o);
    chk("R8 no result", h, 0);
    for (int i = 0; i < 1; i++) begin
      repeat (1) @(negedge clk);
    end
    stop_r = 1'b1;
    @(negedge clk); stop_r = 1'b0;
    collect(8, h, r, o);
    chk("R8 pulses", h, 1);
    chk("R8 coarse from start", int'(r[RW-1:FW]), 10);

    // R9: reset mid-measurement
    @(negedge clk); start_r = 1'b1;
    @(negedge clk); start_r = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 re-reset result", int'(res), 0);
    chk("R9 re-reset ovf", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk); stop_r = 1'b1;
    @(negedge clk); stop_r = 1'b0;
    collect(8, h, r, o);
    chk("R9 counter cleared", h, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule